// File: doc/BRIEF.md
# Round-Robin Channel Monitoring Sequencer

This block walks a fixed list of ten monitored quantities (one temperature sensor, seven voltage inputs and two fan tachometers) one at a time. For each channel it asks an external converter for a conversion, waits for the converter to report completion, and stores the result in a small value store that the host reads by address. After every stored result it waits a programmable gap, so a full pass takes a fixed time. That time roughly doubles when the temperature sensor is set to its high-resolution mode. A one-cycle strobe marks the end of each pass, so that downstream status logic can update.

The sequencer runs only while the start control is high and the interrupt-clear control is low. Dropping either one aborts a conversion in progress, and the next run begins again at the temperature channel. A host read that hits a stored result while a conversion is in flight aborts that conversion and requests it again. The value store has no reset, so its contents survive both hardware reset and a soft re-initialisation.

Top module: `mon_seq_top`

## Requirements
- R1: Channels are converted in a fixed order, identified on `conv_chan` as 0 = temperature, 1..7 = voltage inputs 0..6, 8 = fan 1, 9 = fan 2. After channel 9 the order wraps to channel 0.
- R2: `conv_req` stays low unless `cfg_start` is 1 and `cfg_int_clr` is 0. When both conditions first hold, the first request follows one cycle later and is for channel 0.
- R3: Each conversion begins with a single-cycle `conv_req` pulse. The sequencer then waits for `conv_done` and stores `conv_result`. A non-temperature channel keeps only bits 7:0 of the result, and bits 11:8 of the stored value are zero.
- R4: The stored temperature keeps all 12 result bits when `temp_hires` is 1. When `temp_hires` is 0 it keeps bits 8:0, and bits 11:9 of the stored value are zero.
- R5: After each completion the sequencer waits GAP_CYCLES cycles (2*GAP_CYCLES when `temp_hires` is 1) before the next `conv_req`. Request-to-request spacing is therefore 1 + (converter latency) + gap cycles.
- R6: `pass_done` is a single-cycle pulse in the cycle after the fan 2 result is stored, once per pass.
- R7: The host address map is: temperature at 7'h27, voltage input k at 7'h20+k, fan 1 at 7'h28, fan 2 at 7'h29. `host_rd_data` is valid in the cycle after `host_rd_en`. It shows the last completed conversion of that channel. An unmapped address reads 0.
- R8: A mapped host read during a conversion aborts it. `conv_abort` is high in the next cycle and `conv_req` is low in that cycle. The cycle after that re-requests the same channel. If `conv_done` arrives in the same cycle as the read, the result is stored instead.
- R9: A host read while no conversion is in flight raises no `conv_abort` and does not shift the timing or order of the next request.
- R10: Dropping the run condition during a conversion gives a one-cycle `conv_abort` and no further requests. Restarting begins at channel 0.
- R11: Stored results are not cleared by `rst_n`.
- R12: `conv_req` and `conv_abort` are never high in the same cycle.
- R13: After reset, `conv_req`, `conv_abort`, `pass_done` and `host_rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start control; monitoring needs it high |
| cfg_int_clr | input | 1 | Interrupt-clear control; monitoring needs it low |
| temp_hires | input | 1 | 1 selects the 12-bit temperature result and the doubled gap |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | 7 | Host read address |
| host_rd_data | output | 12 | Read data, one cycle after the strobe |
| conv_req | output | 1 | Single-cycle conversion request |
| conv_chan | output | 4 | Channel being converted |
| conv_abort | output | 1 | Single-cycle abort of the conversion in flight |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 12 | Converter result, valid with conv_done |
| pass_done | output | 1 | End-of-pass strobe |

## Verification
The bench builds the block with GAP_CYCLES = 8 and drives it from a converter model with a fixed four-cycle latency. A channel slot is therefore 13 cycles at low resolution and 21 at high resolution. Several whole passes and their exact request spacing fit into a few hundred cycles. With the short slot, the bench can place a host read on a chosen cycle: in the first cycle of a conversion, or in the first gap cycle after a completion. This exercises the restart and no-effect paths deterministically.

// File: rtl/mon_seq_pkg.sv
`timescale 1ns/1ps
// Shared constants, state encoding and address map of the monitoring sequencer.
// Assumes exactly ten channels; the address map is fixed.
package mon_seq_pkg;
    localparam int NUM_CH    = 10;
    localparam int CH_W      = 4;
    localparam int RES_W     = 12;
    localparam int ADDR_W    = 7;
    localparam int TEMP_LO_W = 9;
    localparam int OTHER_W   = 8;

    localparam logic [CH_W-1:0]   CH_TEMP        = 4'd0;
    localparam logic [CH_W-1:0]   CH_FAN1        = 4'd8;
    localparam logic [CH_W-1:0]   CH_FAN2        = 4'd9;
    localparam logic [ADDR_W-1:0] ADDR_VOLT_BASE = 7'h20;
    localparam logic [ADDR_W-1:0] ADDR_TEMP      = 7'h27;
    localparam logic [ADDR_W-1:0] ADDR_FAN_BASE  = 7'h28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CONV,
        ST_RESTART,
        ST_GAP
    } seq_state_t;

    // Host address of a channel's stored result.
    function automatic logic [ADDR_W-1:0] ch_to_addr(input logic [CH_W-1:0] ch);
        logic [ADDR_W-1:0] a;
        if (ch == CH_TEMP)
            a = ADDR_TEMP;
        else if (ch >= CH_FAN1)
            a = ADDR_FAN_BASE + ADDR_W'(ch - CH_FAN1);
        else
            a = ADDR_VOLT_BASE + ADDR_W'(ch - 4'd1);
        return a;
    endfunction
endpackage

// File: rtl/mon_gap_timer.sv
`timescale 1ns/1ps
// Down-counter that times the idle gap after each stored result.
// Loaded with the gap length minus one; expired is high while the count is zero.
// Assumes GAP_CYCLES >= 1. High resolution doubles the gap.
module mon_gap_timer #(
    parameter int GAP_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic hires,
    output logic expired
);
    localparam int LEN_HI = 2 * GAP_CYCLES;
    localparam int CNT_W  = $clog2(LEN_HI + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= hires ? CNT_W'(LEN_HI - 1) : CNT_W'(GAP_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mon_value_store.sv
`timescale 1ns/1ps
// Result storage with a host read port.
// The storage registers have no reset by design; only the read data register is reset.
// Read data is registered: valid one cycle after rd_en. A same-cycle write is seen by the next read.
module mon_value_store
    import mon_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [RES_W-1:0]  rd_data
);
    logic [RES_W-1:0] val_q [NUM_CH];
    logic [NUM_CH-1:0] match;
    logic [CH_W-1:0]   rd_slot;

    // Per-channel address comparators.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign match[g] = rd_en && (rd_addr == ch_to_addr(CH_W'(g)));
    end

    // Encode the matching comparator into a slot index.
    always_comb begin
        rd_slot = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (match[i]) rd_slot = CH_W'(i);
    end

    assign rd_hit = |match;

    // Store the written result into its channel slot (no reset).
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++)
            if (wr_en && wr_ch == CH_W'(i))
                val_q[i] <= wr_data;
    end

    // Capture read data; unmapped addresses read zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_hit ? val_q[rd_slot] : '0;
    end
endmodule

// File: rtl/mon_seq_ctrl.sv
`timescale 1ns/1ps
// Channel sequencing state machine.
// IDLE -> ISSUE (one-cycle request) -> CONV (wait done) -> GAP -> ISSUE of next channel.
// A read hit in CONV goes through RESTART (abort pulse) back to ISSUE for the same channel.
// Loss of run aborts a conversion in ISSUE or CONV and returns to IDLE at the temperature channel.
// Assumes the converter gives exactly one conv_done per request that is not aborted.
module mon_seq_ctrl
    import mon_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rd_hit,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             temp_hires,
    input  logic             gap_expired,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_chan,
    output logic             conv_abort,
    output logic             pass_done,
    output logic             gap_load,
    output logic             wr_en,
    output logic [CH_W-1:0]  wr_ch,
    output logic [RES_W-1:0] wr_data,
    output logic             in_conv
);
    seq_state_t      state_q, state_d;
    logic [CH_W-1:0] chan_q, chan_d;
    logic            abort_q, abort_d;
    logic            pass_q, pass_d;

    // Next-state, abort and write decisions.
    always_comb begin
        state_d  = state_q;
        chan_d   = chan_q;
        abort_d  = 1'b0;
        pass_d   = 1'b0;
        gap_load = 1'b0;
        wr_en    = 1'b0;
        if (state_q != ST_IDLE && !run) begin
            state_d = ST_IDLE;
            chan_d  = CH_TEMP;
            abort_d = (state_q == ST_ISSUE) || (state_q == ST_CONV);
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (run) begin
                        state_d = ST_ISSUE;
                        chan_d  = CH_TEMP;
                    end
                end
                ST_ISSUE: state_d = ST_CONV;
                ST_CONV: begin
                    if (conv_done) begin
                        wr_en    = 1'b1;
                        gap_load = 1'b1;
                        pass_d   = (chan_q == CH_FAN2);
                        state_d  = ST_GAP;
                    end else if (rd_hit) begin
                        abort_d = 1'b1;
                        state_d = ST_RESTART;
                    end
                end
                ST_RESTART: state_d = ST_ISSUE;
                ST_GAP: begin
                    if (gap_expired) begin
                        state_d = ST_ISSUE;
                        chan_d  = (chan_q == CH_FAN2) ? CH_TEMP : chan_q + 4'd1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Format the result by channel: temperature width by resolution, others 8 bits.
    always_comb begin
        if (chan_q == CH_TEMP)
            wr_data = temp_hires ? conv_result
                                 : {{(RES_W-TEMP_LO_W){1'b0}}, conv_result[TEMP_LO_W-1:0]};
        else
            wr_data = {{(RES_W-OTHER_W){1'b0}}, conv_result[OTHER_W-1:0]};
    end

    // State, channel and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= CH_TEMP;
            abort_q <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            abort_q <= abort_d;
            pass_q  <= pass_d;
        end
    end

    assign conv_req   = (state_q == ST_ISSUE);
    assign conv_chan  = chan_q;
    assign conv_abort = abort_q;
    assign pass_done  = pass_q;
    assign wr_ch      = chan_q;
    assign in_conv    = (state_q == ST_CONV);
endmodule

// File: rtl/mon_seq_top.sv
`timescale 1ns/1ps
// Round-robin monitoring sequencer top: control, gap timer and value store.
// Runs while cfg_start is high and cfg_int_clr is low. GAP_CYCLES sets the pause after each result.
module mon_seq_top
    import mon_seq_pkg::*;
#(
    parameter int GAP_CYCLES = 20_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic              cfg_int_clr,
    input  logic              temp_hires,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [RES_W-1:0]  host_rd_data,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_abort,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              pass_done
);
    logic             run;
    logic             rd_hit;
    logic             gap_load;
    logic             gap_expired;
    logic             wr_en;
    logic [CH_W-1:0]  wr_ch;
    logic [RES_W-1:0] wr_data;
    logic             in_conv;

    assign run = cfg_start && !cfg_int_clr;

    mon_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .rd_hit      (rd_hit),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .temp_hires  (temp_hires),
        .gap_expired (gap_expired),
        .conv_req    (conv_req),
        .conv_chan   (conv_chan),
        .conv_abort  (conv_abort),
        .pass_done   (pass_done),
        .gap_load    (gap_load),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_data     (wr_data),
        .in_conv     (in_conv)
    );

    mon_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .hires   (temp_hires),
        .expired (gap_expired)
    );

    mon_value_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (wr_data),
        .rd_en   (host_rd_en),
        .rd_addr (host_rd_addr),
        .rd_hit  (rd_hit),
        .rd_data (host_rd_data)
    );
endmodule

// File: rtl/mon_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the monitoring sequencer, bound into the top.
module mon_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       rd_hit,
    input logic       in_conv,
    input logic       conv_req,
    input logic [3:0] conv_chan,
    input logic       conv_abort,
    input logic       conv_done,
    input logic       pass_done
);
    logic [3:0] last_ch;
    logic [3:0] next_ch;

    assign next_ch = (last_ch == 4'd9) ? 4'd0 : last_ch + 4'd1;

    // Remember the channel of the most recent request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_ch <= 4'd9;
        else if (conv_req)
            last_ch <= conv_chan;
    end

    AST_REQ_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_req && conv_abort)); // R12
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !conv_req); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R3
    AST_PASS_AFTER_FAN2: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> $past(conv_done && in_conv && conv_chan == 4'd9)); // R6
    AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && rd_hit && !conv_done && run) |=> conv_abort); // R8
    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_conv && !run) |=> conv_abort); // R10
    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_chan == next_ch || conv_chan == last_ch || conv_chan == 4'd0)); // R1
endmodule

bind mon_seq_top mon_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .rd_hit     (rd_hit),
    .in_conv    (in_conv),
    .conv_req   (conv_req),
    .conv_chan  (conv_chan),
    .conv_abort (conv_abort),
    .conv_done  (conv_done),
    .pass_done  (pass_done)
);

// File: tb/sim_mon_seq_top.sv
`timescale 1ns/1ps
module sim_mon_seq_top;
    localparam int GAP = 8;
    localparam int LAT = 4;
    localparam int WD  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_int_clr = 1'b0;
    logic        temp_hires = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [6:0]  host_rd_addr = '0;
    logic [11:0] host_rd_data;
    logic        conv_req;
    logic [3:0]  conv_chan;
    logic        conv_abort;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        pass_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int log_n = 0;
    int log_ch [64];
    int log_t [64];
    int pass_cnt = 0;
    int bad_pass = 0;
    int overlap = 0;
    int last_done = -1;
    logic [11:0] exp_val [10];
    logic        busy = 1'b0;
    int          cnt = 0;
    logic [3:0]  mch = '0;
    logic [7:0]  gen = 8'h11;

    always #2.5 clk = ~clk;

    mon_seq_top #(.GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_int_clr(cfg_int_clr),
        .temp_hires(temp_hires), .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_abort(conv_abort), .conv_done(conv_done), .conv_result(conv_result),
        .pass_done(pass_done)
    );

    function automatic logic [6:0] addr_of(input int ch);
        if (ch == 0) return 7'h27;
        if (ch >= 8) return 7'(8'h28 + ch - 8);
        return 7'(8'h20 + ch - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Converter model, pass/overlap monitor and watchdog; acts just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (cyc > WD) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
            finish_run();
        end
        conv_done = 1'b0;
        if (!rst_n) begin
            busy = 1'b0;
        end else begin
            if (conv_req && conv_abort) overlap++;
            if (pass_done) begin
                pass_cnt++;
                if (last_done != 9) bad_pass++;
            end
            if (conv_abort) begin
                busy = 1'b0;
            end else if (conv_req) begin
                busy = 1'b1;
                cnt  = LAT;
                mch  = conv_chan;
                if (log_n < 64) begin
                    log_ch[log_n] = int'(conv_chan);
                    log_t[log_n]  = cyc;
                    log_n++;
                end
            end else if (busy) begin
                if (cnt == 1) begin
                    conv_result = {4'hA ^ mch, gen};
                    conv_done   = 1'b1;
                    if (mch == 4'd0)
                        exp_val[mch] = temp_hires ? conv_result : (conv_result & 12'h1FF);
                    else
                        exp_val[mch] = conv_result & 12'h0FF;
                    last_done = int'(mch);
                    busy = 1'b0;
                    gen  = gen + 8'h07;
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic host_read(input logic [6:0] a, output logic [11:0] d);
        @(negedge clk);
        host_rd_en   = 1'b1;
        host_rd_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rd_data;
    endtask

    task automatic clear_log();
        log_n = 0;
        pass_cnt = 0;
        bad_pass = 0;
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 2000 && log_n < n; i++) @(negedge clk);
    endtask

    task automatic wait_pass();
        @(negedge clk);
        for (int i = 0; i < 2000 && !pass_done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(conv_req == 1'b0,   "R13 conv_req after reset", conv_req, 0);
        chk(conv_abort == 1'b0, "R13 conv_abort after reset", conv_abort, 0);
        chk(pass_done == 1'b0,  "R13 pass_done after reset", pass_done, 0);
        chk(host_rd_data == 12'h0, "R13 read data after reset", host_rd_data, 0);
    endtask

    task automatic t_gating();
        clear_log();
        repeat (40) @(negedge clk);
        chk(log_n == 0, "R2 no request while start low", log_n, 0);
        cfg_start = 1'b1;
        cfg_int_clr = 1'b1;
        repeat (40) @(negedge clk);
        chk(log_n == 0, "R2 no request while int-clear high", log_n, 0);
        cfg_int_clr = 1'b0;
        @(negedge clk);
        chk(conv_req == 1'b1, "R2 request one cycle after run", conv_req, 1);
        chk(conv_chan == 4'd0, "R2 first channel is temperature", conv_chan, 0);
    endtask

    task automatic t_order();
        int bad;
        bad = 0;
        wait_log(21);
        for (int i = 0; i < 21; i++) if (log_ch[i] != i % 10) bad++;
        chk(bad == 0, "R1 channel order over two passes", bad, 0);
        chk(pass_cnt == 2, "R6 one pass strobe per pass", pass_cnt, 2);
        chk(bad_pass == 0, "R6 pass strobe follows fan 2", bad_pass, 0);
        chk(log_t[1] - log_t[0] == 1 + LAT + GAP, "R5 low-res request spacing",
            log_t[1] - log_t[0], 1 + LAT + GAP);
        chk(log_t[10] - log_t[0] == 10 * (1 + LAT + GAP), "R5 low-res pass length",
            log_t[10] - log_t[0], 10 * (1 + LAT + GAP));
    endtask

    task automatic t_values();
        logic [11:0] d;
        int bad;
        bad = 0;
        wait_pass();
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            host_read(addr_of(i), d);
            if (d !== exp_val[i]) begin
                bad++;
                $display("FAIL R3/R7 channel %0d actual=%0h expected=%0h", i, d, exp_val[i]);
            end
        end
        chk(bad == 0, "R3 R7 stored values by address", bad, 0);
        host_read(7'h27, d);
        chk((d & 12'hE00) == 12'h0, "R4 low-res temperature keeps 9 bits", d, exp_val[0]);
        clear_log();
        temp_hires = 1'b1;
        cfg_start = 1'b1;
        wait_log(3);
        chk(log_t[2] - log_t[1] == 1 + LAT + 2 * GAP, "R5 high-res request spacing",
            log_t[2] - log_t[1], 1 + LAT + 2 * GAP);
        wait_pass();
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        host_read(7'h27, d);
        chk(d == exp_val[0] && (d & 12'hE00) != 12'h0, "R4 high-res temperature keeps 12 bits",
            d, exp_val[0]);
        temp_hires = 1'b0;
    endtask

    task automatic t_read_restart();
        logic [11:0] old;
        int c;
        clear_log();
        cfg_start = 1'b1;
        wait_log(3);
        c = log_ch[2];
        old = exp_val[c];
        @(negedge clk);
        host_rd_en = 1'b1;
        host_rd_addr = addr_of(c);
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(conv_abort == 1'b1 && conv_req == 1'b0, "R8 abort after read in conversion",
            {conv_abort, conv_req}, 2);
        chk(host_rd_data == old, "R7 read returns last completed value", host_rd_data, old);
        @(negedge clk);
        chk(conv_req == 1'b1 && conv_chan == 4'(c), "R8 same channel re-requested",
            conv_chan, c);
    endtask

    task automatic t_read_idle();
        int c;
        for (int i = 0; i < 200 && !conv_done; i++) @(negedge clk);
        c = int'(conv_chan);
        @(negedge clk);
        host_rd_en = 1'b1;
        host_rd_addr = 7'h27;
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(conv_abort == 1'b0, "R9 no abort for read in gap", conv_abort, 0);
        chk(host_rd_data == exp_val[0], "R7 temperature read in gap", host_rd_data, exp_val[0]);
        repeat (GAP - 1) @(negedge clk);
        chk(conv_req == 1'b1 && conv_chan == 4'((c + 1) % 10), "R9 next request timing kept",
            {conv_req, conv_chan}, {1'b1, 4'((c + 1) % 10)});
    endtask

    task automatic t_stop();
        int n0;
        for (int i = 0; i < 200 && !conv_req; i++) @(negedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        @(negedge clk);
        chk(conv_abort == 1'b1 && conv_req == 1'b0, "R10 abort on stop",
            {conv_abort, conv_req}, 2);
        n0 = log_n;
        repeat (10) @(negedge clk);
        chk(log_n == n0, "R10 no request after stop", log_n - n0, 0);
        cfg_start = 1'b1;
        @(negedge clk);
        chk(conv_req == 1'b1 && conv_chan == 4'd0, "R10 restart at temperature", conv_chan, 0);
        chk(overlap == 0, "R12 request and abort never together", overlap, 0);
        cfg_start = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_keep();
        logic [11:0] v1;
        logic [11:0] v2;
        host_read(7'h27, v1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_req == 1'b0 && pass_done == 1'b0 && host_rd_data == 12'h0,
            "R13 outputs after second reset", host_rd_data, 0);
        host_read(7'h27, v2);
        chk(v2 == v1, "R11 stored value survives reset", v2, v1);
        host_read(7'h30, v2);
        chk(v2 == 12'h0, "R7 unmapped address reads zero", v2, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_order();
        t_values();
        t_read_restart();
        t_read_idle();
        t_stop();
        t_keep();
        finish_run();
    end
endmodule